// File: doc/BRIEF.md
# Programmable Periodic Tick Timer

The block produces a periodic interrupt derived from a 32768 Hz reference, which reaches it as a one-cycle enable pulse on the system clock. A four-bit select field chooses a power-of-two prescaler between the reference and a down-counter. The down-counter is loaded from a programmable reload value. Each time it runs out, it sets a sticky pending flag that drives a level interrupt, reloads itself and keeps counting.

Software sees four word registers through a simple write strobe and a combinational read port: control, reload count, live current count and interrupt status. The counter starts and stops only on transitions of the control enable bits, never on their levels. A reload value that is too small to be useful is discarded.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control (address 0), reload (address 1), current count (address 2) and status (address 3) registers read zero, `tick_irq_o` is low and the counter is stopped.
- R2: While running, the current count decrements once every 2^S reference pulses, where S is control bits [7:4].
- R3: A write to the reload register (address 1) is stored only when the written value is greater than 2. Otherwise the previous value is kept.
- R4: A control write that changes the tick enable (bit 8) from 0 to 1 loads the current count from the reload value and starts counting. This happens only when the written global enable (bit 0) is 1 and the reload value is nonzero. Setting only the global enable does not start the counter.
- R5: Rewriting the control register with enable bits that are already set neither reloads nor restarts the counter.
- R6: A control write that changes bit 8 or bit 0 from 1 to 0 stops the counter, and the current count then holds its value.
- R7: When a decrement would take the count from 1 to 0, status bit 0 is set, `tick_irq_o` goes high, and the count reloads from the reload register while counting continues.
- R8: Writing 1 to status bit 0 (address 3) clears the pending flag and lowers `tick_irq_o`. Writing 0 leaves it unchanged. An expiry in the same cycle as the clear wins.
- R9: Address 2 returns the live value of the down-counter.
- R10: The prescaler restarts from zero whenever a control write changes the select field. The first decrement after such a change therefore comes on the 2^S-th reference pulse.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle pulse at the 32768 Hz reference rate |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 control, 1 reload, 2 current, 3 status) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| tick_irq_o | output | 1 | Level tick interrupt, high while pending |

## Verification
On every cycle, the assertions check the following behaviour:
- the counter holds its value while stopped;
- it decrements by exactly one per prescaled step;
- it reloads on expiry and never sits at zero while running;
- the reload register ignores small values;
- the prescaler clears on a select change;
- an expiry raises the interrupt.

Only the bench scenarios can show the end-to-end behaviour. These are the exact reference-pulse count at which each expiry happens for each select and reload value, the edge-only start and stop rules, and the write-one-to-clear semantics seen at the ports.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned ADDR_W     = 2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_CUR    = 2'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

  localparam int unsigned GLB_BIT  = 0;
  localparam int unsigned SEL_LSB  = 4;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned TICK_BIT = 8;
  localparam int unsigned MIN_RELOAD = 2;

  typedef struct packed {
    logic             tick_en;
    logic [SEL_W-1:0] sel;
    logic             glb_en;
  } ctrl_t;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PRESC_W = 15,
  parameter int unsigned SEL_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clear_i,
  output logic             step_o
);
  logic [PRESC_W-1:0] cnt_q;
  logic [PRESC_W-1:0] mask;

  assign mask   = ~({PRESC_W{1'b1}} << sel_i);
  assign step_o = ref_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (ref_i)   cnt_q <= cnt_q + 1'b1;
  end

  p_clear_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/tick_downcounter.sv
module tick_downcounter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cur_q;
  logic             run_q;

  assign cur_o    = cur_q;
  assign expire_o = run_q && step_i && (cur_q == CNT_W'(1)) && !load_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cur_q <= reload_i;
      run_q <= 1'b1;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (run_q && step_i) begin
      cur_q <= (cur_q == CNT_W'(1)) ? reload_i : cur_q - 1'b1;
    end
  end

  p_hold_stopped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !load_i) |=> $stable(cur_q));
  p_step_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && step_i && !load_i && !stop_i && cur_q > CNT_W'(1))
    |=> (cur_q == $past(cur_q) - 1'b1));
  p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cur_q == $past(reload_i)));
  p_no_zero_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cur_q != '0));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned PRESC_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tick_irq_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] reload_q, cur;
  logic             pend_q;
  logic             wr_ctrl, wr_reload, wr_status;
  logic             start, stop, sel_chg, step, expire;

  assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
  assign wr_reload = wr_en_i && (addr_i == A_RELOAD);
  assign wr_status = wr_en_i && (addr_i == A_STATUS);

  assign ctrl_d.glb_en  = wdata_i[GLB_BIT];
  assign ctrl_d.sel     = wdata_i[SEL_LSB +: SEL_W];
  assign ctrl_d.tick_en = wdata_i[TICK_BIT];

  // Edge-only start and stop, judged against the stored bits
  assign start   = wr_ctrl && ctrl_d.glb_en && ctrl_d.tick_en && !ctrl_q.tick_en
                   && (reload_q != '0);
  assign stop    = wr_ctrl && ((ctrl_q.tick_en && !ctrl_d.tick_en) ||
                               (ctrl_q.glb_en && !ctrl_d.glb_en));
  assign sel_chg = wr_ctrl && (ctrl_d.sel != ctrl_q.sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_reload && (wdata_i[CNT_W-1:0] > CNT_W'(MIN_RELOAD)))
        reload_q <= wdata_i[CNT_W-1:0];
      if (expire)                      pend_q <= 1'b1;
      else if (wr_status && wdata_i[0]) pend_q <= 1'b0;
    end
  end

  tick_prescaler #(.PRESC_W(PRESC_W), .SEL_W(SEL_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ref_i   (ref_tick_i),
    .sel_i   (ctrl_q.sel),
    .clear_i (sel_chg),
    .step_o  (step)
  );

  tick_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .stop_i   (stop),
    .step_i   (step),
    .reload_i (reload_q),
    .cur_o    (cur),
    .expire_o (expire)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[GLB_BIT]             = ctrl_q.glb_en;
        rdata_o[SEL_LSB +: SEL_W]    = ctrl_q.sel;
        rdata_o[TICK_BIT]            = ctrl_q.tick_en;
      end
      A_RELOAD: rdata_o = DATA_W'(reload_q);
      A_CUR:    rdata_o = DATA_W'(cur);
      default:  rdata_o[0] = pend_q;
    endcase
  end

  assign tick_irq_o = pend_q;

  p_small_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_reload && (wdata_i[CNT_W-1:0] <= CNT_W'(MIN_RELOAD))) |=> $stable(reload_q));
  p_expire_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> tick_irq_o);
  p_clear_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status && wdata_i[0] && !expire) |=> !tick_irq_o);
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        tick_irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  tick_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_tick_i(ref_tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_irq_o(tick_irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic pulse();
    @(negedge clk_i);
    ref_tick_i = 1'b1;
    @(negedge clk_i);
    ref_tick_i = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input bit ten, input int sel, input bit glb);
    return {23'd0, ten, 4'(sel), 3'd0, glb};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check("R1 reg", v, 0);
    end
    check("R1 irq", {31'd0, tick_irq_o}, 0);

    // R4 zero reload blocks start
    wr(0, ctl(1, 0, 1));
    pulse(); pulse();
    rd(2, v); check("R4 zero reload cur", v, 0);
    rd(3, v); check("R4 zero reload status", v, 0);
    wr(0, 0);

    // R3 minimum reload
    wr(1, 2); rd(1, v); check("R3 write 2", v, 0);
    wr(1, 7); rd(1, v); check("R3 write 7", v, 7);
    wr(1, 1); rd(1, v); check("R3 write 1", v, 7);
    wr(1, 0); rd(1, v); check("R3 write 0", v, 7);
    wr(1, 3); rd(1, v); check("R3 write 3", v, 3);
    wr(1, 32'h10000); rd(1, v); check("R3 write large", v, 32'h10000);

    // R2 R7 R9 R10 sweep over select and reload
    for (int s = 0; s < 4; s++) begin
      for (int n = 3; n <= 6; n++) begin
        int p;
        p = 1 << s;
        wr(1, n);
        wr(0, ctl(0, s ^ 1, 1));
        wr(0, ctl(0, s, 1));          // R10 prescaler restarted
        wr(0, ctl(1, s, 1));
        rd(2, v); check("R4 start loads", v, n);
        for (int k = 1; k <= 2 * n * p; k++) begin
          int m;
          logic [31:0] ec;
          pulse();
          m  = (k / p) % n;
          ec = (m == 0) ? n : n - m;
          rd(2, v); check("R2 R9 R10 cur", v, ec);
          rd(3, v); check("R7 status", v, ((k / p) >= n) ? 1 : 0);
          check("R7 irq", {31'd0, tick_irq_o}, ((k / p) >= n) ? 1 : 0);
        end
        wr(0, ctl(0, s, 1));
        wr(3, 1);
      end
    end

    // R5 level rewrite does not reload
    wr(0, ctl(0, 1, 1)); wr(0, ctl(0, 0, 1));
    wr(1, 5);
    wr(0, ctl(1, 0, 1));
    pulse(); pulse();
    rd(2, v); check("R5 before rewrite", v, 3);
    wr(0, ctl(1, 0, 1));
    rd(2, v); check("R5 after rewrite", v, 3);
    pulse();
    rd(2, v); check("R5 still running", v, 2);

    // R6 stop on tick enable fall
    wr(0, ctl(0, 0, 1));
    pulse(); pulse(); pulse();
    rd(2, v); check("R6 tick fall hold", v, 2);
    rd(3, v); check("R6 tick fall status", v, 0);

    // R6 stop on global fall
    wr(0, ctl(1, 0, 1));
    pulse();
    rd(2, v); check("R6 restart", v, 4);
    wr(0, ctl(1, 0, 0));
    pulse(); pulse();
    rd(2, v); check("R6 global fall hold", v, 4);

    // R4 global rise alone does not start
    wr(0, ctl(1, 0, 1));
    pulse();
    rd(2, v); check("R4 global rise only", v, 4);

    // R8 status write semantics
    wr(0, 0);
    wr(0, ctl(1, 0, 1));
    for (int i = 0; i < 5; i++) pulse();
    rd(3, v); check("R8 pending set", v, 1);
    wr(3, 0);
    rd(3, v); check("R8 write zero", v, 1);
    check("R8 irq kept", {31'd0, tick_irq_o}, 1);
    wr(3, 1);
    rd(3, v); check("R8 write one", v, 0);
    check("R8 irq cleared", {31'd0, tick_irq_o}, 0);

    finish_run();
  end
endmodule